// File: doc/BRIEF.md
# Bit test and branch unit

This block executes the pair of "test one bit, then branch" instructions of a 32-bit processor core. Each issued operation carries a source register value, a bit-position operand (a register value or a literal), a signed word-granular displacement, the current instruction pointer, and a select that says whether the branch is taken when the tested bit is set or when it is clear.

On the clock edge where the issue strobe is high, the unit registers three results. The first is a 3-bit condition code that reflects the tested bit's value. The second is the next instruction pointer, which is either the branch target or the following word. The third is a one-cycle taken flag that a fetch stage can use to flush. A matching one-cycle result strobe marks every completed operation. Decode, operand fetch and fault reporting sit outside the block.

Top module: `bittest_branch_unit`

## Requirements
- R1: The tested bit is `src_i[pos_i % 32]`: only the low 5 bits of `pos_i` select the bit, and any value of 32 or more behaves like its low 5 bits.
- R2: After an operation the condition code `cc_o` is 3'b010 if the tested bit was 1 and 3'b000 if it was 0, for both values of `op_i`.
- R3: With `op_i` = 1 (branch when set), a tested bit of 1 takes the branch and a tested bit of 0 falls through.
- R4: With `op_i` = 0 (branch when clear), a tested bit of 0 takes the branch and a tested bit of 1 falls through.
- R5: A taken branch sets `next_ip_o` to `{ip_i[31:2] + sext(disp_i[12:2]), 2'b00}`. `disp_i[1:0]` and `ip_i[1:0]` are ignored, and the word sum wraps modulo 2^30.
- R6: A fall-through sets `next_ip_o` to `{ip_i[31:2] + 1, 2'b00}`, wrapping modulo 2^30.
- R7: Results register on the rising edge where `valid_i` is 1. On an edge where `valid_i` is 0, `cc_o` and `next_ip_o` keep their values.
- R8: `done_o` is 1 for exactly the cycle after each accepted operation. `taken_o` is 1 in that cycle only if the branch was taken, and both are 0 otherwise.
- R9: While `rst_n` is low, `cc_o` is 3'b000, `next_ip_o` is 0, and `taken_o` and `done_o` are 0. Assertion of reset acts at once, and its release takes effect after two clock edges.
- R10: The displacement reaches from -4096 bytes (`disp_i` = 13'h1000) to +4092 bytes (`disp_i` = 13'h0FFC) around `ip_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Issue strobe for one operation |
| op_i | input | 1 | 1 = branch when bit set, 0 = branch when bit clear |
| src_i | input | 32 | Source register value |
| pos_i | input | 32 | Bit-position operand |
| disp_i | input | 13 | Signed displacement in bytes; bits [1:0] ignored |
| ip_i | input | 32 | Current instruction pointer |
| cc_o | output | 3 | Condition code result |
| next_ip_o | output | 32 | Next instruction pointer |
| taken_o | output | 1 | Branch taken, one cycle |
| done_o | output | 1 | Result strobe, one cycle |

## Verification
The checker assumes that `valid_i` stays low while reset is asserted and until the internal reset release has passed. Without this, a strobe seen in the last reset cycle would look like an accepted operation whose result never appeared. The checker also assumes that the operands are stable only on edges where `valid_i` is high, and it compares each result against those sampled operands and nothing else. The bench holds `valid_i` at 0 through reset and for several cycles after release. It changes operands only at falling edges, and it drives deliberately different operands while `valid_i` is low to show that they leave the outputs alone.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int XLEN   = 32;
  localparam int DISP_W = 13;
  localparam int CC_W   = 3;

  typedef enum logic {
    OP_BR_CLR = 1'b0,
    OP_BR_SET = 1'b1
  } bt_op_e;

  localparam logic [CC_W-1:0] CC_BIT_ONE  = 3'b010;
  localparam logic [CC_W-1:0] CC_BIT_ZERO = 3'b000;
endpackage

// File: rtl/bt_rst_sync.sv
module bt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/bt_bit_pick.sv
module bt_bit_pick #(
  parameter int XLEN  = 32,
  parameter int POS_W = 32,
  localparam int IDX_W = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]  src_i,
  input  logic [POS_W-1:0] pos_i,
  output logic             bit_o
);
  logic [IDX_W-1:0] idx;
  logic             unused_pos_hi;

  assign idx           = pos_i[IDX_W-1:0];
  assign unused_pos_hi = ^pos_i[POS_W-1:IDX_W];
  assign bit_o         = src_i[idx];
endmodule

// File: rtl/bt_ip_calc.sv
module bt_ip_calc #(
  parameter int XLEN   = 32,
  parameter int DISP_W = 13,
  localparam int WORD_W = XLEN - 2,
  localparam int EXT_W  = XLEN - DISP_W
) (
  input  logic [XLEN-1:0]   ip_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              take_i,
  output logic [XLEN-1:0]   next_ip_o
);
  logic [WORD_W-1:0] ip_word;
  logic [WORD_W-1:0] disp_word;
  logic [WORD_W-1:0] tgt_word;
  logic [WORD_W-1:0] seq_word;
  logic              unused_low;

  assign ip_word    = ip_i[XLEN-1:2];
  assign disp_word  = {{EXT_W{disp_i[DISP_W-1]}}, disp_i[DISP_W-1:2]};
  assign unused_low = ^{ip_i[1:0], disp_i[1:0]};

  always_comb begin
    tgt_word  = ip_word + disp_word;
    seq_word  = ip_word + {{(WORD_W-1){1'b0}}, 1'b1};
    next_ip_o = {(take_i ? tgt_word : seq_word), 2'b00};
  end
endmodule

// File: rtl/bittest_branch_unit.sv
module bittest_branch_unit
  import bt_pkg::*;
#(
  parameter int POS_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic              op_i,
  input  logic [XLEN-1:0]   src_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [XLEN-1:0]   ip_i,
  output logic [CC_W-1:0]   cc_o,
  output logic [XLEN-1:0]   next_ip_o,
  output logic              taken_o,
  output logic              done_o
);
  logic            rst_sync_n;
  logic            bit_val;
  logic            take;
  bt_op_e          op;
  logic [XLEN-1:0] ip_calc;

  logic [CC_W-1:0] cc_q,   cc_d;
  logic [XLEN-1:0] nip_q,  nip_d;
  logic            tk_q,   tk_d;
  logic            done_q, done_d;

  bt_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bt_bit_pick #(.XLEN(XLEN), .POS_W(POS_W)) u_bit_pick (
    .src_i (src_i),
    .pos_i (pos_i),
    .bit_o (bit_val)
  );

  assign op   = bt_op_e'(op_i);
  assign take = (op == OP_BR_SET) ? bit_val : ~bit_val;

  bt_ip_calc #(.XLEN(XLEN), .DISP_W(DISP_W)) u_ip_calc (
    .ip_i      (ip_i),
    .disp_i    (disp_i),
    .take_i    (take),
    .next_ip_o (ip_calc)
  );

  // next-state
  always_comb begin
    cc_d   = cc_q;
    nip_d  = nip_q;
    tk_d   = 1'b0;
    done_d = 1'b0;
    if (valid_i) begin
      cc_d   = bit_val ? CC_BIT_ONE : CC_BIT_ZERO;
      nip_d  = ip_calc;
      tk_d   = take;
      done_d = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cc_q   <= '0;
      nip_q  <= '0;
      tk_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cc_q   <= cc_d;
      nip_q  <= nip_d;
      tk_q   <= tk_d;
      done_q <= done_d;
    end
  end

  assign cc_o      = cc_q;
  assign next_ip_o = nip_q;
  assign taken_o   = tk_q;
  assign done_o    = done_q;
endmodule

// File: rtl/bt_branch_chk.sv
module bt_branch_chk #(
  parameter int XLEN   = 32,
  parameter int POS_W  = 32,
  parameter int DISP_W = 13,
  localparam int IDX_W = $clog2(XLEN)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid_i,
  input logic              op_i,
  input logic [XLEN-1:0]   src_i,
  input logic [POS_W-1:0]  pos_i,
  input logic [DISP_W-1:0] disp_i,
  input logic [XLEN-1:0]   ip_i,
  input logic [2:0]        cc_o,
  input logic [XLEN-1:0]   next_ip_o,
  input logic              taken_o,
  input logic              done_o
);
  logic unused_disp;
  assign unused_disp = ^disp_i;

  AST_CC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_o == 3'b000) || (cc_o == 3'b010)); // R2

  AST_CC_FROM_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(valid_i) |-> (cc_o[1] == $past(src_i[pos_i[IDX_W-1:0]]))); // R1

  AST_TAKEN_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (taken_o == (cc_o[1] == $past(op_i)))); // R3 R4

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    next_ip_o[1:0] == 2'b00); // R5

  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !taken_o) |-> (next_ip_o[XLEN-1:2] == $past(ip_i[XLEN-1:2]) + 1'b1)); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(valid_i) |-> ($stable(cc_o) && $stable(next_ip_o))); // R7

  AST_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(valid_i) |-> (!taken_o && !done_o)); // R8
endmodule

bind bittest_branch_unit bt_branch_chk #(.XLEN(32), .POS_W(POS_W), .DISP_W(13)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .valid_i   (valid_i),
  .op_i      (op_i),
  .src_i     (src_i),
  .pos_i     (pos_i),
  .disp_i    (disp_i),
  .ip_i      (ip_i),
  .cc_o      (cc_o),
  .next_ip_o (next_ip_o),
  .taken_o   (taken_o),
  .done_o    (done_o)
);

// File: tb/bittest_branch_unit_tb_top.sv
module bittest_branch_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        op;
    logic [31:0] src;
    logic [31:0] pos;
    logic [12:0] disp;
    logic [31:0] ip;
    logic [2:0]  cc;
    logic [31:0] nip;
    logic        tk;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 32'h0000_0001, 32'd0,          13'h0010, 32'h0000_1000, 3'b010, 32'h0000_1010, 1'b1},
    '{1'b1, 32'h0000_0001, 32'd1,          13'h0010, 32'h0000_1000, 3'b000, 32'h0000_1004, 1'b0},
    '{1'b0, 32'h8000_0000, 32'd31,         13'h0020, 32'h0000_2000, 3'b010, 32'h0000_2004, 1'b0},
    '{1'b0, 32'h7FFF_FFFF, 32'd31,         13'h0020, 32'h0000_2000, 3'b000, 32'h0000_2020, 1'b1},
    '{1'b1, 32'h0000_0004, 32'd34,         13'h1000, 32'h0000_8000, 3'b010, 32'h0000_7000, 1'b1},
    '{1'b0, 32'h0000_0000, 32'hFFFF_FFE5,  13'h0FFC, 32'h0000_8000, 3'b000, 32'h0000_8FFC, 1'b1},
    '{1'b1, 32'hFFFF_FFFF, 32'd7,          13'h1FFC, 32'h0000_0000, 3'b010, 32'hFFFF_FFFC, 1'b1},
    '{1'b0, 32'h0000_0000, 32'd3,          13'h0007, 32'h0000_0100, 3'b000, 32'h0000_0104, 1'b1},
    '{1'b1, 32'h0000_0000, 32'd3,          13'h0010, 32'hFFFF_FFFC, 3'b000, 32'h0000_0000, 1'b0},
    '{1'b1, 32'h0000_0000, 32'd0,          13'h0000, 32'h0000_1002, 3'b000, 32'h0000_1004, 1'b0}
  };

  logic        clk;
  logic        rst_n;
  logic        valid;
  logic        op;
  logic [31:0] src;
  logic [31:0] pos;
  logic [12:0] disp;
  logic [31:0] ip;
  logic [2:0]  cc;
  logic [31:0] nip;
  logic        taken;
  logic        done;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  bittest_branch_unit dut_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid), .op_i(op), .src_i(src),
    .pos_i(pos), .disp_i(disp), .ip_i(ip), .cc_o(cc), .next_ip_o(nip),
    .taken_o(taken), .done_o(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_next(input logic [31:0] ipv, input logic [12:0] d, input logic tk);
    logic [29:0] w;
    if (tk) w = ipv[31:2] + {{19{d[12]}}, d[12:2]};
    else    w = ipv[31:2] + 30'd1;
    return {w, 2'b00};
  endfunction

  task automatic issue(input logic o, input logic [31:0] s, input logic [31:0] p,
                       input logic [12:0] d, input logic [31:0] i);
    @(negedge clk);
    op = o; src = s; pos = p; disp = d; ip = i; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic run_model(input string req, input logic o, input logic [31:0] s,
                           input logic [31:0] p, input logic [12:0] d, input logic [31:0] i);
    logic b;
    logic tk;
    b  = s[p[4:0]];
    tk = o ? b : ~b;
    issue(o, s, p, d, i);
    check({req, " cc"},    {29'd0, cc},   b ? 32'd2 : 32'd0);
    check({req, " taken"}, {31'd0, taken}, {31'd0, tk});
    check({req, " nip"},   nip,            m_next(i, d, tk));
    check({req, " done"},  {31'd0, done},  32'd1);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R7: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; valid = 1'b0; op = 1'b0; src = '0; pos = '0; disp = '0; ip = '0;
    #1;
    // R9: reset state
    check("R9 cc",    {29'd0, cc}, 32'd0);
    check("R9 nip",   nip, 32'd0);
    check("R9 taken", {31'd0, taken}, 32'd0);
    check("R9 done",  {31'd0, done}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table: R1 R2 R3 R4 R5 R6 R10
    for (int k = 0; k < NVEC; k++) begin
      issue(VECS[k].op, VECS[k].src, VECS[k].pos, VECS[k].disp, VECS[k].ip);
      check($sformatf("R2 vec%0d cc", k),    {29'd0, cc},    {29'd0, VECS[k].cc});
      check($sformatf("R3 R4 vec%0d taken", k), {31'd0, taken}, {31'd0, VECS[k].tk});
      check($sformatf("R5 R6 R10 vec%0d nip", k), nip, VECS[k].nip);
    end

    // every bit position, both opcodes, both bit values, positions >= 32 (R1)
    for (int p = 0; p < 32; p++) begin
      logic [31:0] one;
      one = 32'h1 << p;
      run_model("R3 R1 set/one",  1'b1, one,  p,               13'(p*4),        32'h4000 + p*16);
      run_model("R4 R1 clr/zero", 1'b0, ~one, p + 32*(p+1),    13'h1000 + p*4,  32'h9000 + p*8);
      run_model("R4 R2 clr/one",  1'b0, one,  p + 64,          13'h0FFC,        32'h1_0000 + p*4);
      run_model("R3 R2 set/zero", 1'b1, ~one, 32'hFFFF_FFE0|p, 13'h0100,        32'hFFFF_FF00 + p*4);
    end

    // R7 R8: idle cycles with changed operands leave results alone
    issue(1'b1, 32'h0000_0010, 32'd4, 13'h0040, 32'h0000_3000);
    @(negedge clk);
    check("R8 taken one cycle", {31'd0, taken}, 32'd0);
    check("R8 done one cycle",  {31'd0, done},  32'd0);
    op = 1'b0; src = 32'h0; pos = 32'd4; disp = 13'h1000; ip = 32'h0000_5000;
    repeat (3) @(negedge clk);
    check("R7 cc held",  {29'd0, cc}, 32'd2);
    check("R7 nip held", nip, 32'h0000_3040);
    check("R8 taken idle", {31'd0, taken}, 32'd0);
    check("R8 done idle",  {31'd0, done},  32'd0);

    // R8: back-to-back operations each give a pulse
    @(negedge clk);
    op = 1'b1; src = 32'h1; pos = 32'd0; disp = 13'h0008; ip = 32'h0000_0200; valid = 1'b1;
    @(negedge clk);
    check("R8 b2b first taken", {31'd0, taken}, 32'd1);
    src = 32'h0;
    @(negedge clk);
    valid = 1'b0;
    check("R8 b2b second taken", {31'd0, taken}, 32'd0);
    check("R8 b2b second done",  {31'd0, done},  32'd1);
    check("R6 b2b second nip",   nip, 32'h0000_0204);

    // R9: reset mid-run clears at once
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9 mid cc",  {29'd0, cc}, 32'd0);
    check("R9 mid nip", nip, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule